// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block drives an external successive-approximation converter core through a scan over a contiguous range of eight analog inputs. Software sets a first channel, a last channel, a repeat bit and a clock-divide code, then pulses a start strobe. The sequencer presents one channel at a time to the core and raises a convert request. It waits for the core's done strobe and stores the 10-bit result, tagged with its channel number, in one result slot per channel.

The scan always steps upward. It wraps from channel 7 to channel 0 when the last channel is numerically below the first. With the repeat bit clear, the scan stops after the last channel. With it set, the scan begins again at the first channel until software asks it to halt. A free-running divider derives the conversion clock enable from the peripheral clock. The core uses that enable to pace its conversion.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the first channel, last channel and divide code are all 0 and the repeat bit is 0. A start strobe with no prior configuration converts only channel 0, and `conv_clk_en` pulses every 2 clocks.
- R2: A scan converts channels in increasing order from the first to the last channel inclusive. When the first and last channel are equal, exactly one conversion occurs.
- R3: When the last channel is below the first channel, the channel index wraps from 7 to 0. For example, first 2 and last 1 gives 2,3,4,5,6,7,0,1.
- R4: With the repeat bit 0, the block stops after the last channel and returns to idle. `scan_done` pulses in the same cycle as the `res_valid` of the last channel.
- R5: With the repeat bit 1, the block restarts at the first channel after the last channel. A `scan_halt` pulse ends the scan once the conversion in progress completes. No further conversion begins after that.
- R6: `conv_clk_en` pulses once every 2^(code+1) clocks for divide codes 0 to 14. Code 15 behaves as code 14, with a period of 32768 clocks.
- R7: Each completed conversion gives a one-cycle `res_valid` with `res_ch` and `res_data` equal to the core's data. It also updates that channel's slot, and the slot is readable through `rd_ch` as `rd_data` and `rd_tag`.
- R8: `ovr_flag` is set when a result is written into a slot whose previous result has not been acknowledged by `rd_ack`. A one-cycle `ovr_clr` of 1 clears the flag.
- R9: `busy` is high from the cycle after an accepted start strobe until the block is idle again. Start strobes and configuration writes made while `busy` is high have no effect.
- R10: `conv_req` stays high with a stable `conv_sel` until `conv_done`. It is low for at least one cycle before the next conversion begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe (accepted only while idle) |
| cfg_first_ch | input | 3 | First channel of the scan |
| cfg_last_ch | input | 3 | Last channel of the scan |
| cfg_repeat | input | 1 | 0 = single pass, 1 = repeat until halted |
| cfg_div_code | input | 4 | Conversion clock divide code |
| scan_go | input | 1 | Start strobe |
| scan_halt | input | 1 | Halt request for a running scan |
| conv_clk_en | output | 1 | Conversion clock enable to the core |
| conv_sel | output | 3 | Channel select to the core |
| conv_req | output | 1 | Convert request to the core |
| conv_done | input | 1 | Conversion finished strobe from the core |
| conv_data | input | 10 | Conversion result from the core |
| res_valid | output | 1 | One-cycle pulse per stored result |
| res_ch | output | 3 | Channel of the stored result |
| res_data | output | 10 | Stored result value |
| scan_done | output | 1 | Pulse when the last channel's result is stored |
| rd_ch | input | 3 | Slot selected for reading |
| rd_ack | input | 1 | Marks the selected slot as read |
| rd_data | output | 10 | Result held in the selected slot |
| rd_tag | output | 3 | Channel tag held in the selected slot |
| ovr_flag | output | 1 | Overrun flag |
| ovr_clr | input | 1 | Write 1 to clear the overrun flag |
| busy | output | 1 | Scan in progress |

## Verification
A wrong channel register or wrap decision shows up at the first `res_valid` after the fault. It appears as an out-of-order `res_ch` within a single conversion time, and the observed channel list is compared entry by entry against the list computed from the first and last codes. A bad termination decision changes the result count and the timing of the `busy` fall by whole conversions. A corrupt divider mask changes the `conv_clk_en` spacing within one period. A lost slot unread bit shows as a wrong `ovr_flag` right after the second write to the same channel.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_t;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_code,
  output logic             clk_en
);
  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam logic [DIV_W-1:0] CODE_MAX = {DIV_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] code_eff;
  logic [DIV_W:0]   shamt;
  logic [CNT_W-1:0] mask;

  always_comb begin
    // reserved top code falls back to the next lower one
    code_eff = (div_code == CODE_MAX) ? CODE_MAX - DIV_W'(1) : div_code;
    shamt    = {1'b0, code_eff} + (DIV_W+1)'(1);
    mask     = ~({CNT_W{1'b1}} << shamt);
    cnt_d    = cnt_q + CNT_W'(1);
    clk_en   = ((cnt_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> !clk_en);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_scan_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_first,
  input  logic [CH_W-1:0]  cfg_last,
  input  logic             cfg_repeat,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             go,
  input  logic             halt,
  input  logic             conv_done,
  output logic             busy,
  output logic             conv_req,
  output logic [CH_W-1:0]  conv_sel,
  output logic [DIV_W-1:0] div_code,
  output logic             capture,
  output logic             capture_last
);
  seq_state_t       state_q, state_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic [CH_W-1:0]  first_q, first_d, last_q, last_d;
  logic             rep_q, rep_d, halt_q, halt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             at_last;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    halt_d  = halt_q;
    first_d = first_q;
    last_d  = last_q;
    rep_d   = rep_q;
    div_d   = div_q;
    at_last = (ch_q == last_q);
    capture      = (state_q == ST_CONV) && conv_done;
    capture_last = capture && at_last;

    if (state_q == ST_IDLE && cfg_we) begin
      first_d = cfg_first;
      last_d  = cfg_last;
      rep_d   = cfg_repeat;
      div_d   = cfg_div;
    end

    if (state_q != ST_IDLE && halt) halt_d = 1'b1;

    case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = ST_ARM;
          ch_d    = first_q;
          halt_d  = 1'b0;
        end
      end
      ST_ARM:  state_d = ST_CONV;
      ST_CONV: begin
        if (conv_done) begin
          if (halt_q || (at_last && !rep_q)) begin
            state_d = ST_IDLE;
            halt_d  = 1'b0;
          end else begin
            state_d = ST_ARM;
            ch_d    = at_last ? first_q : ch_q + CH_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      halt_q  <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
      rep_q   <= 1'b0;
      div_q   <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      halt_q  <= halt_d;
      first_q <= first_d;
      last_q  <= last_d;
      rep_q   <= rep_d;
      div_q   <= div_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign conv_req = (state_q == ST_CONV);
  assign conv_sel = ch_q;
  assign div_code = div_q;

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(first_q) && $stable(last_q) && $stable(rep_q) && $stable(div_q)));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> (conv_req && $stable(conv_sel)));

  assert_req_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done) |=> !conv_req);

  assert_first_ch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM && $past(state_q) == ST_IDLE) |-> (ch_q == first_q));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              capture_last,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              rd_ack,
  input  logic              ovr_clr,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_ch,
  output logic [DATA_W-1:0] res_data,
  output logic              scan_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [CH_W-1:0]   rd_tag,
  output logic              ovr_flag
);
  localparam int NCH = 1 << CH_W;

  logic [NCH-1:0][DATA_W-1:0] data_q, data_d;
  logic [NCH-1:0][CH_W-1:0]   tag_q, tag_d;
  logic [NCH-1:0]             unread_q, unread_d;
  logic                       ovr_q, ovr_d;
  logic                       vld_q, done_q;
  logic [CH_W-1:0]            rch_q;
  logic [DATA_W-1:0]          rdat_q;

  always_comb begin
    data_d   = data_q;
    tag_d    = tag_q;
    unread_d = unread_q;
    for (int i = 0; i < NCH; i++) begin
      if (rd_ack && rd_ch == CH_W'(i)) unread_d[i] = 1'b0;
      if (capture && wr_ch == CH_W'(i)) begin
        data_d[i]   = wr_data;
        tag_d[i]    = wr_ch;
        unread_d[i] = 1'b1;
      end
    end
    ovr_d = (capture && unread_q[wr_ch]) || (ovr_q && !ovr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      tag_q    <= '0;
      unread_q <= '0;
      ovr_q    <= 1'b0;
      vld_q    <= 1'b0;
      done_q   <= 1'b0;
      rch_q    <= '0;
      rdat_q   <= '0;
    end else begin
      data_q   <= data_d;
      tag_q    <= tag_d;
      unread_q <= unread_d;
      ovr_q    <= ovr_d;
      vld_q    <= capture;
      done_q   <= capture_last;
      if (capture) begin
        rch_q  <= wr_ch;
        rdat_q <= wr_data;
      end
    end
  end

  assign res_valid = vld_q;
  assign res_ch    = rch_q;
  assign res_data  = rdat_q;
  assign scan_done = done_q;
  assign rd_data   = data_q[rd_ch];
  assign rd_tag    = tag_q[rd_ch];
  assign ovr_flag  = ovr_q;

  assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(capture));

  assert_done_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> res_valid);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 10,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_first_ch,
  input  logic [CH_W-1:0]   cfg_last_ch,
  input  logic              cfg_repeat,
  input  logic [DIV_W-1:0]  cfg_div_code,
  input  logic              scan_go,
  input  logic              scan_halt,
  output logic              conv_clk_en,
  output logic [CH_W-1:0]   conv_sel,
  output logic              conv_req,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_ch,
  output logic [DATA_W-1:0] res_data,
  output logic              scan_done,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [CH_W-1:0]   rd_tag,
  output logic              ovr_flag,
  input  logic              ovr_clr,
  output logic              busy
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [DIV_W-1:0] div_code;
  logic             capture, capture_last;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  adc_seq_fsm #(.CH_W(CH_W), .DIV_W(DIV_W)) u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_we(cfg_we), .cfg_first(cfg_first_ch), .cfg_last(cfg_last_ch),
    .cfg_repeat(cfg_repeat), .cfg_div(cfg_div_code),
    .go(scan_go), .halt(scan_halt), .conv_done(conv_done),
    .busy(busy), .conv_req(conv_req), .conv_sel(conv_sel),
    .div_code(div_code), .capture(capture), .capture_last(capture_last)
  );

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .div_code(div_code), .clk_en(conv_clk_en)
  );

  adc_result_bank #(.CH_W(CH_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_int_n),
    .capture(capture), .capture_last(capture_last),
    .wr_ch(conv_sel), .wr_data(conv_data),
    .rd_ch(rd_ch), .rd_ack(rd_ack), .ovr_clr(ovr_clr),
    .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data),
    .scan_done(scan_done), .rd_data(rd_data), .rd_tag(rd_tag),
    .ovr_flag(ovr_flag)
  );

endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_TICKS  = 2;
  localparam int WATCHDOG   = 190000;
  localparam int NVEC       = 6;
  // {first[2:0], last[2:0], div[3:0], expected count[3:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {3'd0, 3'd0, 4'd0, 4'd1},
    {3'd0, 3'd3, 4'd1, 4'd4},
    {3'd2, 3'd1, 4'd0, 4'd8},
    {3'd7, 3'd7, 4'd2, 4'd1},
    {3'd5, 3'd2, 4'd1, 4'd6},
    {3'd6, 3'd7, 4'd0, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_repeat, scan_go, scan_halt, rd_ack, ovr_clr;
  logic [2:0] cfg_first_ch, cfg_last_ch, rd_ch;
  logic [3:0] cfg_div_code;
  logic conv_clk_en, conv_req, conv_done;
  logic [2:0] conv_sel, res_ch, rd_tag;
  logic [9:0] conv_data, res_data, rd_data;
  logic res_valid, scan_done, ovr_flag, busy;

  int n_checks = 0, n_fail = 0, cycles = 0;
  logic [2:0] obs_ch [64];
  logic [9:0] last_data;
  int obs_n = 0, done_n = 0, req_rise_n = 0;
  logic req_prev = 1'b0;
  int tick_cnt = 0;
  logic [6:0] seq_no = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_first_ch(cfg_first_ch),
    .cfg_last_ch(cfg_last_ch), .cfg_repeat(cfg_repeat), .cfg_div_code(cfg_div_code),
    .scan_go(scan_go), .scan_halt(scan_halt), .conv_clk_en(conv_clk_en),
    .conv_sel(conv_sel), .conv_req(conv_req), .conv_done(conv_done),
    .conv_data(conv_data), .res_valid(res_valid), .res_ch(res_ch),
    .res_data(res_data), .scan_done(scan_done), .rd_ch(rd_ch), .rd_ack(rd_ack),
    .rd_data(rd_data), .rd_tag(rd_tag), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr),
    .busy(busy)
  );

  // converter core model: done after LAT_TICKS enables, data = {channel, sequence}
  always @(posedge clk) begin
    if (!rst_n) begin
      conv_done <= 1'b0; conv_data <= '0; tick_cnt <= 0;
    end else if (conv_done) begin
      conv_done <= 1'b0;
    end else if (conv_req) begin
      if (conv_clk_en) begin
        if (tick_cnt == LAT_TICKS - 1) begin
          conv_done <= 1'b1;
          conv_data <= {conv_sel, seq_no};
          seq_no    <= seq_no + 7'd1;
          tick_cnt  <= 0;
        end else tick_cnt <= tick_cnt + 1;
      end
    end else tick_cnt <= 0;
  end

  // output monitor, away from the active edge
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (res_valid) begin
      obs_ch[obs_n[5:0]] <= res_ch;
      last_data <= res_data;
      obs_n <= obs_n + 1;
    end
    if (scan_done) done_n <= done_n + 1;
    if (conv_req && !req_prev) req_rise_n <= req_rise_n + 1;
    req_prev <= conv_req;
    if (cycles > WATCHDOG) begin
      n_checks = n_checks + 1; n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic do_cfg(input logic [2:0] f, input logic [2:0] l, input logic r, input logic [3:0] d);
    cfg_first_ch = f; cfg_last_ch = l; cfg_repeat = r; cfg_div_code = d; cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic go();
    scan_go = 1'b1; step(1); scan_go = 1'b0;
  endtask

  task automatic clear_obs();
    step(1);
    obs_n = 0; done_n = 0; req_rise_n = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      if (!busy) break;
      step(1);
    end
    step(3);
  endtask

  task automatic measure(input string req, input int exp);
    int gap;
    gap = 0;
    for (int i = 0; i < 70000; i++) begin if (conv_clk_en) break; step(1); end
    step(1); gap = 1;
    for (int i = 0; i < 70000; i++) begin if (conv_clk_en) break; step(1); gap++; end
    check(gap == exp, req, gap, exp);
  endtask

  task automatic check_seq(input string req, input logic [2:0] f, input int n);
    for (int k = 0; k < n; k++) begin
      logic [2:0] e;
      e = f + 3'(k);
      check(obs_ch[k] == e, req, int'(obs_ch[k]), int'(e));
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_repeat = 0; scan_go = 0; scan_halt = 0;
    rd_ack = 0; ovr_clr = 0; cfg_first_ch = 0; cfg_last_ch = 0; cfg_div_code = 0; rd_ch = 0;
    step(4);
    rst_n = 1'b1;
    step(4);

    // reset state
    check(busy == 1'b0, "R9 reset busy", busy, 0);
    check(conv_req == 1'b0, "R10 reset req", conv_req, 0);
    check(ovr_flag == 1'b0, "R8 reset ovr", ovr_flag, 0);
    check(res_valid == 1'b0 && scan_done == 1'b0, "R7 reset valid", res_valid, 0);
    measure("R1 default divider period", 2);

    // default configuration: only channel 0
    clear_obs(); go(); wait_idle();
    check(obs_n == 1, "R1 default count", obs_n, 1);
    check(obs_ch[0] == 3'd0, "R1 default channel", obs_ch[0], 0);

    // vector table of single-pass scans
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] f, l; logic [3:0] d; int n;
      {f, l, d} = VEC[v][13:4]; n = int'(VEC[v][3:0]);
      do_cfg(f, l, 1'b0, d);
      clear_obs(); go(); wait_idle();
      check(obs_n == n, (l < f) ? "R3 wrap count" : "R2 count", obs_n, n);
      check_seq((l < f) ? "R3 wrap order" : "R2 order", f, n);
      check(done_n == 1, "R4 scan_done count", done_n, 1);
      check(busy == 1'b0, "R4 idle after pass", busy, 0);
      check(req_rise_n == n, "R10 one request per conversion", req_rise_n, n);
      check(last_data[9:7] == obs_ch[n-1], "R7 data from core", int'(last_data[9:7]), int'(obs_ch[n-1]));
    end

    // divider codes
    do_cfg(0, 0, 0, 4'd3); measure("R6 code 3", 16);
    do_cfg(0, 0, 0, 4'd0); measure("R6 code 0", 2);
    do_cfg(0, 0, 0, 4'hF); measure("R6 code 15 fallback", 32768);

    // repeat mode with halt
    do_cfg(3'd6, 3'd1, 1'b1, 4'd0);
    clear_obs(); go();
    for (int i = 0; i < 5000; i++) begin if (obs_n >= 5) break; step(1); end
    scan_halt = 1'b1; step(1); scan_halt = 1'b0;
    wait_idle();
    check(obs_n == 6, "R5 halt after current conversion", obs_n, 6);
    check_seq("R5 restart order", 3'd6, 4);
    check(obs_ch[4] == 3'd6 && obs_ch[5] == 3'd7, "R5 restarts at first", obs_ch[4], 6);
    check(done_n == 1, "R5 scan_done per pass", done_n, 1);

    // ignored start and configuration while busy
    do_cfg(3'd1, 3'd2, 1'b0, 4'd0);
    clear_obs(); go(); step(2);
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    do_cfg(3'd5, 3'd5, 1'b1, 4'd3);
    go();
    wait_idle();
    check(obs_n == 2 && obs_ch[0] == 3'd1 && obs_ch[1] == 3'd2, "R9 start while busy ignored", obs_n, 2);
    clear_obs(); go(); wait_idle();
    check(obs_n == 2 && obs_ch[0] == 3'd1, "R9 write while busy ignored", obs_n, 2);
    measure("R9 divider write while busy ignored", 2);

    // result slots and overrun
    for (int c = 0; c < 8; c++) begin rd_ch = 3'(c); rd_ack = 1'b1; step(1); end
    rd_ack = 1'b0; ovr_clr = 1'b1; step(1); ovr_clr = 1'b0;
    check(ovr_flag == 1'b0, "R8 cleared", ovr_flag, 0);
    do_cfg(3'd4, 3'd4, 1'b0, 4'd0);
    clear_obs(); go(); wait_idle();
    check(ovr_flag == 1'b0, "R8 first write no overrun", ovr_flag, 1'b0);
    rd_ch = 3'd4; step(1);
    check(rd_tag == 3'd4, "R7 slot tag", rd_tag, 4);
    check(rd_data == last_data, "R7 slot data", rd_data, last_data);
    clear_obs(); go(); wait_idle();
    check(ovr_flag == 1'b1, "R8 unread overwrite sets flag", ovr_flag, 1);
    check(rd_data == last_data, "R7 slot updated", rd_data, last_data);
    ovr_clr = 1'b1; step(1); ovr_clr = 1'b0; step(1);
    check(ovr_flag == 1'b0, "R8 write one clears", ovr_flag, 0);
    rd_ack = 1'b1; step(1); rd_ack = 1'b0;
    clear_obs(); go(); wait_idle();
    check(ovr_flag == 1'b0, "R8 acknowledged slot no overrun", ovr_flag, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule